// File: doc/BRIEF.md
# Posted Write Buffer with Per-Bus Sync Barrier

This bridge sits between a CPU request port and two peripheral write buses. A CPU write that falls into one of the two peripheral register windows is accepted in the same cycle. The bridge stores it in a small queue for that bus and delivers it to the peripheral later. Each bus has its own queue, and writes leave it in the order they were accepted, one per valid/ready handshake. Everything else goes straight through to a pass-through port without any buffering. That covers reads of ordinary addresses and writes outside both windows.

Because writes are posted, software may need to know that a write has actually landed, for example that an interrupt flag has been cleared before the handler returns. Each bus therefore has a synchronization address. A read of that address is held, with the CPU ready signal low, until the queue of that bus is empty. The read then returns zero. A sync read holds only for its own bus; the other bus's queue does not delay it.

Top module: `pwb_bridge`

## Requirements
- R1: A CPU write into a window whose queue is not full is accepted in the same cycle it is presented (`cpu_ready` high). It later appears on that bus's `per_*` outputs with identical address, data and byte enables.
- R2: Bus 0 (index 0 of the `per_*` arrays) owns addresses 0x0000–0x01FF, 0x0280–0x037F, 0x0400–0x063F and 0x0C00–0x0FFF. Bus 1 owns 0xC000–0xFFFF. A write to any other address goes to the pass-through port and is not buffered.
- R3: With DEPTH (4) writes held in a bus queue, a further write to that bus keeps `cpu_ready` low. It is accepted in the cycle after the next handshake on that bus, and the queue never holds more than DEPTH entries.
- R4: Each bus delivers its writes in acceptance order, one per clock edge at which `per_valid` and `per_ready` are both high. While `per_ready` is low, `per_valid`, `per_addr`, `per_wdata` and `per_be` hold steady.
- R5: A read of address 0x0240, of any size, stalls while the bus 0 queue holds entries. It completes in the cycle after the last bus 0 handshake and returns zero data.
- R6: A read of address 0x0380 behaves the same way for bus 1 and is not delayed by entries in the bus 0 queue.
- R7: A sync read presented while its queue is empty completes in the cycle it is presented.
- R8: Ordinary reads, and writes outside both windows, drive `pt_req` for as long as the request is held. `cpu_ready` follows `pt_ready` and `cpu_rdata` follows `pt_rdata`. Buffered writes and sync reads never raise `pt_req`.
- R9: Reset empties both queues. Writes queued before reset are never delivered, and `per_valid` is low during and after reset.
- R10: A full or stalled queue on one bus does not delay acceptance of writes to the other bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_be | input | DW/8 | CPU byte enables |
| cpu_ready | output | 1 | Request completes at the clock edge where this is high |
| cpu_rdata | output | DW | Read data (zero for sync reads) |
| per_valid | output | 2 | Per-bus queued write available |
| per_ready | input | 2 | Per-bus peripheral accepts the write |
| per_addr | output | 2×AW | Per-bus write address |
| per_wdata | output | 2×DW | Per-bus write data |
| per_be | output | 2×DW/8 | Per-bus byte enables |
| pt_req | output | 1 | Pass-through request |
| pt_we | output | 1 | Pass-through write flag |
| pt_addr | output | AW | Pass-through address |
| pt_wdata | output | DW | Pass-through write data |
| pt_be | output | DW/8 | Pass-through byte enables |
| pt_ready | input | 1 | Pass-through target ready |
| pt_rdata | input | DW | Pass-through read data |

## Verification
The following are checked on every cycle against an occupancy count rebuilt from the port handshakes:
- the queue occupancy bound;
- agreement between `per_valid` and that count;
- stability of a write held back by the peripheral;
- the rule that a sync read completes only when its bus count is zero, and at once when it is;
- the zero sync data and the pass-through ready and data routing.

The bench scenarios cover what a per-cycle property cannot:
- the address windows, swept at every 64-byte block edge;
- the exact number of stall cycles for a full queue and for sync reads behind several entries;
- the delivery order under random peripheral back-pressure;
- that writes queued before a reset never appear.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   localparam int NBUS = 2;

   typedef enum logic [1:0] {
      ROUTE_IDLE,
      ROUTE_PASS,
      ROUTE_BUF,
      ROUTE_SYNC
   } route_e;
endpackage

// File: rtl/pwb_decode.sv
module pwb_decode #(
   parameter int AW = 16,
   parameter int NWIN = 1,
   parameter logic [NWIN*AW-1:0] LO = '0,
   parameter logic [NWIN*AW-1:0] HI = '1
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   logic [NWIN-1:0] w_hit;

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      localparam logic [AW-1:0] BASE = LO[i*AW +: AW];
      localparam logic [AW-1:0] SPAN = HI[i*AW +: AW] - LO[i*AW +: AW];
      logic [AW-1:0] offset;
      assign offset   = addr - BASE;
      assign w_hit[i] = (offset <= SPAN);
   end

   assign hit = |w_hit;
endmodule

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
   parameter int W = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] in_data,
   input  logic         out_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign do_push = push & ~full;
   assign do_pop  = out_valid & out_ready;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_mod
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   assign out_data  = mem[rd_ptr];
   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);
   assign out_valid = ~empty;
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge
   import pwb_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int DEPTH = 4,
   parameter int NWIN_A = 4,
   parameter logic [NWIN_A*AW-1:0] WIN_A_LO = {16'h0C00, 16'h0400, 16'h0280, 16'h0000},
   parameter logic [NWIN_A*AW-1:0] WIN_A_HI = {16'h0FFF, 16'h063F, 16'h037F, 16'h01FF},
   parameter int NWIN_B = 1,
   parameter logic [NWIN_B*AW-1:0] WIN_B_LO = 16'hC000,
   parameter logic [NWIN_B*AW-1:0] WIN_B_HI = 16'hFFFF,
   parameter logic [AW-1:0] SYNC_A = 16'h0240,
   parameter logic [AW-1:0] SYNC_B = 16'h0380
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cpu_req,
   input  logic                             cpu_we,
   input  logic [AW-1:0]                    cpu_addr,
   input  logic [DW-1:0]                    cpu_wdata,
   input  logic [DW/8-1:0]                  cpu_be,
   output logic                             cpu_ready,
   output logic [DW-1:0]                    cpu_rdata,
   output logic [NBUS-1:0]                  per_valid,
   input  logic [NBUS-1:0]                  per_ready,
   output logic [NBUS-1:0][AW-1:0]          per_addr,
   output logic [NBUS-1:0][DW-1:0]          per_wdata,
   output logic [NBUS-1:0][DW/8-1:0]        per_be,
   output logic                             pt_req,
   output logic                             pt_we,
   output logic [AW-1:0]                    pt_addr,
   output logic [DW-1:0]                    pt_wdata,
   output logic [DW/8-1:0]                  pt_be,
   input  logic                             pt_ready,
   input  logic [DW-1:0]                    pt_rdata
);
   localparam int BW = DW / 8;
   localparam int EW = AW + DW + BW;
   localparam logic [NBUS-1:0][AW-1:0] SYNC_TAB = {SYNC_B, SYNC_A};

   initial begin
      assert (DEPTH >= 2) else $fatal(1, "pwb_bridge: DEPTH must be at least 2");
      assert (DW % 8 == 0) else $fatal(1, "pwb_bridge: DW must be whole bytes");
      assert (SYNC_A != SYNC_B) else $fatal(1, "pwb_bridge: sync addresses must differ");
   end

   logic [NBUS-1:0] win_hit, buf_hit, sync_hit, push, full, empty;
   logic [EW-1:0]   entry_q [NBUS];
   route_e          route;

   pwb_decode #(.AW(AW), .NWIN(NWIN_A), .LO(WIN_A_LO), .HI(WIN_A_HI)) u_dec_a (
      .addr(cpu_addr), .hit(win_hit[0]));
   pwb_decode #(.AW(AW), .NWIN(NWIN_B), .LO(WIN_B_LO), .HI(WIN_B_HI)) u_dec_b (
      .addr(cpu_addr), .hit(win_hit[1]));

   for (genvar b = 0; b < NBUS; b++) begin : g_bus
      assign buf_hit[b]  = cpu_req & cpu_we & win_hit[b];
      assign sync_hit[b] = cpu_req & ~cpu_we & (cpu_addr == SYNC_TAB[b]);
      assign push[b]     = buf_hit[b] & ~full[b];

      pwb_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push[b]),
         .in_data  ({cpu_addr, cpu_wdata, cpu_be}),
         .out_ready(per_ready[b]),
         .out_valid(per_valid[b]),
         .out_data (entry_q[b]),
         .full     (full[b]),
         .empty    (empty[b])
      );

      assign {per_addr[b], per_wdata[b], per_be[b]} = entry_q[b];
   end

   always_comb begin
      if (!cpu_req)         route = ROUTE_IDLE;
      else if (|sync_hit)   route = ROUTE_SYNC;
      else if (|buf_hit)    route = ROUTE_BUF;
      else                  route = ROUTE_PASS;
   end

   always_comb begin
      unique case (route)
         ROUTE_PASS: cpu_ready = pt_ready;
         ROUTE_BUF:  cpu_ready = |push;
         ROUTE_SYNC: cpu_ready = |(sync_hit & empty);
         default:    cpu_ready = 1'b0;
      endcase
   end

   assign cpu_rdata = (route == ROUTE_PASS) ? pt_rdata : '0;
   assign pt_req    = (route == ROUTE_PASS);
   assign pt_we     = cpu_we;
   assign pt_addr   = cpu_addr;
   assign pt_wdata  = cpu_wdata;
   assign pt_be     = cpu_be;
endmodule

// File: rtl/pwb_bridge_chk.sv
module pwb_bridge_chk #(
   parameter int NBUS = 2,
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int DEPTH = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cpu_ready,
   input logic [DW-1:0]             cpu_rdata,
   input logic [NBUS-1:0]           per_valid,
   input logic [NBUS-1:0]           per_ready,
   input logic [NBUS-1:0][AW-1:0]   per_addr,
   input logic [NBUS-1:0][DW-1:0]   per_wdata,
   input logic [NBUS-1:0][DW/8-1:0] per_be,
   input logic                      pt_req,
   input logic                      pt_ready,
   input logic [NBUS-1:0]           push,
   input logic [NBUS-1:0]           sync_hit
);
   logic [7:0] occ [NBUS];

   always_ff @(posedge clk) begin
      for (int b = 0; b < NBUS; b++) begin
         if (!rst_n) occ[b] <= '0;
         else occ[b] <= occ[b] + 8'(push[b]) - 8'(per_valid[b] & per_ready[b]);
      end
   end

   for (genvar b = 0; b < NBUS; b++) begin : g_chk
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         occ[b] <= 8'(DEPTH));
      assert_valid_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
         per_valid[b] == (occ[b] != 8'd0));
      assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         per_valid[b] && !per_ready[b] |=> per_valid[b] && $stable(per_addr[b])
            && $stable(per_wdata[b]) && $stable(per_be[b]));
      assert_empty_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
         sync_hit[b] && occ[b] == 8'd0 |-> cpu_ready);
   end

   assert_sync_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit[0] && cpu_ready |-> occ[0] == 8'd0 && cpu_rdata == '0);
   assert_sync_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit[1] && cpu_ready |-> occ[1] == 8'd0 && cpu_rdata == '0);
   assert_pass_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pt_req |-> cpu_ready == pt_ready);
   assert_pass_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push != '0 || sync_hit != '0) |-> !pt_req);
endmodule

bind pwb_bridge pwb_bridge_chk #(.NBUS(pwb_pkg::NBUS), .AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
   .per_valid(per_valid), .per_ready(per_ready), .per_addr(per_addr),
   .per_wdata(per_wdata), .per_be(per_be), .pt_req(pt_req), .pt_ready(pt_ready),
   .push(push), .sync_hit(sync_hit));

// File: tb/pwb_bridge_bench.sv
`timescale 1ns/1ps
module pwb_bridge_bench;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0, cpu_we = 1'b0;
   logic [15:0]       cpu_addr = '0;
   logic [31:0]       cpu_wdata = '0;
   logic [3:0]        cpu_be = '0;
   logic              cpu_ready;
   logic [31:0]       cpu_rdata;
   logic [1:0]        per_valid;
   logic [1:0]        per_ready = 2'b11;
   logic [1:0][15:0]  per_addr;
   logic [1:0][31:0]  per_wdata;
   logic [1:0][3:0]   per_be;
   logic              pt_req, pt_we;
   logic [15:0]       pt_addr;
   logic [31:0]       pt_wdata;
   logic [3:0]        pt_be;
   logic              pt_ready = 1'b1;
   logic [31:0]       pt_rdata;

   assign pt_rdata = {16'hA5A5, pt_addr};

   pwb_bridge u_pwb_bridge (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .per_valid(per_valid), .per_ready(per_ready), .per_addr(per_addr),
      .per_wdata(per_wdata), .per_be(per_be), .pt_req(pt_req), .pt_we(pt_we),
      .pt_addr(pt_addr), .pt_wdata(pt_wdata), .pt_be(pt_be), .pt_ready(pt_ready),
      .pt_rdata(pt_rdata));

   always #2.5 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   logic [51:0] sb [2][64];
   int head [2] = '{0, 0};
   int tail [2] = '{0, 0};
   bit jitter = 1'b0;
   logic [7:0] lfsr = 8'h5B;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   function automatic int route_of(input logic [15:0] a);
      int v = int'(a);
      if (v <= 'h01FF || (v >= 'h0280 && v <= 'h037F) || (v >= 'h0400 && v <= 'h063F) ||
          (v >= 'h0C00 && v <= 'h0FFF)) return 0;
      if (v >= 'hC000) return 1;
      return 2;
   endfunction

   task automatic cpu_op(input logic we, input logic [15:0] a, input logic [31:0] d,
                         input logic [3:0] be, output logic [31:0] rd, output int waits,
                         output logic ptq, output logic [15:0] pta);
      int r;
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
      waits = 0;
      forever begin
         @(negedge clk);
         if (cpu_ready) break;
         waits++;
      end
      rd = cpu_rdata; ptq = pt_req; pta = pt_addr;
      r = route_of(a);
      if (we && r < 2) begin
         sb[r][tail[r] % 64] = {a, d, be};
         tail[r]++;
      end
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d, output int waits);
      logic [31:0] rd; logic ptq; logic [15:0] pta;
      cpu_op(1'b1, a, d, 4'hF, rd, waits, ptq, pta);
   endtask

   // Drain monitor: every handshake must match the next expected write (R4, R1)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            for (int b = 0; b < 2; b++) begin
               if (per_valid[b] && per_ready[b]) begin
                  if (head[b] == tail[b]) begin
                     check(1'b0, "R4", $sformatf("unexpected drain bus%0d", b),
                           {12'h0, per_addr[b], per_wdata[b], per_be[b]}, 64'h0);
                  end else begin
                     check({per_addr[b], per_wdata[b], per_be[b]} == sb[b][head[b] % 64], "R4",
                           $sformatf("drain order bus%0d", b),
                           {12'h0, per_addr[b], per_wdata[b], per_be[b]},
                           {12'h0, sb[b][head[b] % 64]});
                     head[b]++;
                  end
               end
            end
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk); #1;
         if (jitter) begin
            per_ready = lfsr[1:0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      check(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
      summary();
   end

   initial begin
      logic [31:0] rd; int waits; logic ptq; logic [15:0] pta;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(per_valid == 2'b00, "R9", "per_valid in reset", 64'(per_valid), 64'h0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(per_valid == 2'b00 && pt_req == 1'b0, "R9", "idle after reset",
            {62'h0, per_valid}, 64'h0);

      // R2 / R1: window sweep at both edges of every 64-byte block
      for (int i = 0; i < 1024; i++) begin
         for (int j = 0; j < 2; j++) begin
            logic [15:0] a;
            logic [3:0] be;
            int r;
            a = 16'(i * 64 + j * 63);
            be = (i % 3 == 0) ? 4'hF : (i % 3 == 1) ? 4'h3 << (2 * (i % 2)) : 4'h1 << (i % 4);
            cpu_op(1'b1, a, {a, ~a}, be, rd, waits, ptq, pta);
            r = route_of(a);
            if (r == 2)
               check(ptq && pta == a && waits == 0, "R2", $sformatf("pass write %04h", a),
                     {31'h0, ptq, 16'h0, pta}, {32'h1, 16'h0, a});
            else
               check(!ptq && waits == 0, "R1", $sformatf("posted write %04h", a),
                     {31'h0, ptq, 32'(waits)}, 64'h0);
         end
      end
      repeat (4) @(posedge clk);
      check(head[0] == tail[0] && head[1] == tail[1], "R2", "sweep drained",
            64'(tail[0] - head[0] + tail[1] - head[1]), 64'h0);

      // R3 full queue, R10 independence
      per_ready = 2'b10;
      for (int i = 0; i < 4; i++) begin
         wr(16'h0C00 + 16'(4 * i), 32'h1000 + 32'(i), waits);
         check(waits == 0, "R1", "fill accept", 64'(waits), 64'h0);
      end
      wr(16'hC100, 32'hBEEF, waits);
      check(waits == 0, "R10", "bus1 write while bus0 full", 64'(waits), 64'h0);
      fork
         wr(16'h0C40, 32'h2000, waits);
         begin repeat (6) @(posedge clk); #1 per_ready[0] = 1'b1; end
      join
      check(waits == 6, "R3", "stall on full queue", 64'(waits), 64'd6);
      repeat (8) @(posedge clk);
      check(head[0] == tail[0], "R3", "full queue drained", 64'(tail[0] - head[0]), 64'h0);

      // R5 sync barrier for bus 0
      per_ready = 2'b10;
      for (int i = 0; i < 3; i++) wr(16'h0010 + 16'(4 * i), 32'h3000 + 32'(i), waits);
      wr(16'hC200, 32'h3333, waits);
      fork
         cpu_op(1'b0, 16'h0240, 32'h0, 4'h3, rd, waits, ptq, pta);
         begin repeat (6) @(posedge clk); #1 per_ready[0] = 1'b1; end
      join
      check(waits == 8, "R5", "sync0 stall cycles", 64'(waits), 64'd8);
      check(rd == 32'h0 && !ptq, "R5", "sync0 data zero, no pass", {31'h0, ptq, rd}, 64'h0);
      check(head[0] == tail[0], "R5", "bus0 empty at sync0 completion",
            64'(tail[0] - head[0]), 64'h0);

      // R6 sync barrier for bus 1, not held by bus 0 entries
      per_ready = 2'b10;
      per_ready[0] = 1'b0;
      wr(16'h0300, 32'h4000, waits);
      wr(16'h0304, 32'h4001, waits);
      cpu_op(1'b0, 16'h0380, 32'h0, 4'h1, rd, waits, ptq, pta);
      check(waits == 0 && rd == 32'h0, "R6", "sync1 ignores bus0 backlog",
            {32'(waits), rd}, 64'h0);
      per_ready[1] = 1'b0;
      wr(16'hD000, 32'h5000, waits);
      wr(16'hD004, 32'h5001, waits);
      fork
         cpu_op(1'b0, 16'h0380, 32'h0, 4'h3, rd, waits, ptq, pta);
         begin repeat (4) @(posedge clk); #1 per_ready[1] = 1'b1; end
      join
      check(waits == 5, "R6", "sync1 stall cycles", 64'(waits), 64'd5);
      check(rd == 32'h0 && !ptq, "R6", "sync1 data zero", {31'h0, ptq, rd}, 64'h0);
      per_ready = 2'b11;
      repeat (4) @(posedge clk);

      // R7 sync on empty queues
      cpu_op(1'b0, 16'h0240, 32'h0, 4'h1, rd, waits, ptq, pta);
      check(waits == 0, "R7", "sync0 empty completes at once", 64'(waits), 64'h0);
      cpu_op(1'b0, 16'h0380, 32'h0, 4'h3, rd, waits, ptq, pta);
      check(waits == 0, "R7", "sync1 empty completes at once", 64'(waits), 64'h0);

      // R8 pass-through reads and writes
      pt_ready = 1'b0;
      fork
         cpu_op(1'b0, 16'h1234, 32'h0, 4'hF, rd, waits, ptq, pta);
         begin repeat (4) @(posedge clk); #1 pt_ready = 1'b1; end
      join
      check(waits == 3, "R8", "pass read waits on pt_ready", 64'(waits), 64'd3);
      check(rd == 32'hA5A51234 && ptq, "R8", "pass read data", {31'h0, ptq, rd},
            {32'h1, 32'hA5A51234});
      cpu_op(1'b0, 16'h0C00, 32'h0, 4'hF, rd, waits, ptq, pta);
      check(rd == 32'hA5A50C00 && ptq && waits == 0, "R8", "read inside window passes",
            {31'h0, ptq, rd}, {32'h1, 32'hA5A50C00});
      cpu_op(1'b1, 16'h8000, 32'h6000, 4'hF, rd, waits, ptq, pta);
      check(ptq && pta == 16'h8000, "R8", "out-of-window write passes",
            {31'h0, ptq, 16'h0, pta}, {32'h1, 32'h8000});

      // R4 ordering under random back-pressure
      jitter = 1'b1;
      for (int i = 0; i < 24; i++) begin
         if (i % 3 == 2) wr(16'hE000 + 16'(4 * i), 32'h7000 + 32'(i), waits);
         else            wr(16'h0400 + 16'(4 * i), 32'h8000 + 32'(i), waits);
      end
      repeat (60) @(posedge clk);
      jitter = 1'b0;
      per_ready = 2'b11;
      repeat (8) @(posedge clk);
      check(head[0] == tail[0] && head[1] == tail[1], "R4", "jitter run fully drained",
            64'(tail[0] - head[0] + tail[1] - head[1]), 64'h0);

      // R9 reset drops pending writes
      per_ready = 2'b00;
      for (int i = 0; i < 3; i++) wr(16'h0500 + 16'(4 * i), 32'h9000 + 32'(i), waits);
      wr(16'hF000, 32'h9999, waits);
      @(posedge clk); #1 rst_n = 1'b0;
      head[0] = tail[0]; head[1] = tail[1];
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(per_valid == 2'b00, "R9", "valid low in reset", 64'(per_valid), 64'h0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(per_valid == 2'b00, "R9", "valid low after reset", 64'(per_valid), 64'h0);
      per_ready = 2'b11;
      repeat (8) @(posedge clk);
      cpu_op(1'b0, 16'h0240, 32'h0, 4'h1, rd, waits, ptq, pta);
      check(waits == 0, "R9", "sync0 immediate after reset", 64'(waits), 64'h0);

      summary();
   end
endmodule